// File: doc/BRIEF.md
# Chained Data Transfer Sequencer

This block moves single bytes on behalf of peripherals so that the processor does not have to. Each activation source has an enable bit and a request input. When an enabled source raises a request, the sequencer reads a one-byte vector for that source and uses it as an index into a table of transfer records held in memory. It then loads the record, copies one byte from the record's source address to its destination address, and writes the updated record back. Records can be linked: while a record's chain flag is set, the next record in the table is processed in the same activation.

Each record carries a byte counter. In single-shot mode, the transfer that takes the counter from 1 to 0 ends the source's service: its enable bit is cleared and a one-cycle interrupt pulse goes to the processor, tagged with the source number. In cyclic mode the counter and one address are rewound at that point instead, and the interrupt is raised only when the record asks for it. A global non-maskable-interrupt flag cancels activations. For a chosen set of sources, the sequencer also clears the peripheral's status byte during the first record. Requests that arrive while a sequence is running wait and are then served lowest source number first.

Top module: `dts_seq`

## Requirements
- R1: After reset the sequencer is idle (`busy_o` low), all enable bits are 0, no request is pending, and `mem_req_o`, `ack_o` and `irq_o` are low.
- R2: A request on a source whose enable bit is 0 is dropped. It produces no acknowledge and no memory access, and it stays dropped after the source is enabled later.
- R3: If `nmi_i` is high when a pending source is selected, the sequencer acknowledges and discards that request, makes no memory access, and stays idle.
- R4: A single-record activation of source s makes exactly 16 accesses in this order: a read of VEC_BASE+s, which returns index i; reads of bytes 0..6 at REC_BASE+8*i+k; a read of the record's source address; a write of that byte to the destination address; and writes of bytes 1..6 of the updated record.
- R5: Record layout: byte 0 holds the flags (bit0 cyclic mode, bit1 chain, bit2 interrupt-on-reload, bit3 source increments, bit4 destination increments, bit5 rewind the destination when 1 and the source when 0), byte 1 the count, byte 2 the reload value, bytes 3-4 the source address and bytes 5-6 the destination address, low byte first. Each transfer decrements the count by 1 and advances by 1 each address whose increment flag is set. Other addresses stay fixed.
- R6: In single-shot mode, a transfer that takes the count from 1 to 0 writes back a count of 0, clears the source's enable bit, and pulses `irq_o` for one cycle with `irq_src_o` equal to the source.
- R7: In cyclic mode, a transfer from count 1 writes back the reload value as the count and moves the rewound address back by the reload value (256 when the reload value is 0). The enable bit is cleared and `irq_o` is pulsed only if the interrupt-on-reload flag is 1.
- R8: When the chain flag of record i is 1, record i+1 is processed next with no vector read. When the flag is 0, the activation ends.
- R9: A chain flag on the last record (index NUM_REC-1) ends the activation. A vector value of NUM_REC or more ends the activation after the vector read, with no record access.
- R10: For a source whose bit is set in CLR_MASK, byte 0 is written to STAT_BASE+s once per activation, after the first record's reads and before its data read.
- R11: Requests that arrive during an activation are held and served after it ends, in ascending source order. Only one acknowledge bit is high at a time.
- R12: In single-shot mode, a count of 0 decrements to 255 and raises no interrupt.
- R13: `mem_req_o` is asserted only while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SRC | Activation request pulse per source |
| ack_o | output | NUM_SRC | One-cycle pulse when a request is taken or discarded |
| en_set_i | input | NUM_SRC | Pulse that sets enable bits |
| en_o | output | NUM_SRC | Current enable bits |
| nmi_i | input | 1 | Non-maskable-interrupt flag; cancels activations |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid in the cycle after a read strobe |
| irq_o | output | 1 | Interrupt pulse to the processor |
| irq_src_o | output | SW | Source number that goes with `irq_o` |
| busy_o | output | 1 | An activation is in progress |

## Verification
The assertions assume that `nmi_i` is stable around each clock edge and that the memory returns read data exactly one cycle after a read strobe. The bench model of the memory is registered to follow that rule, and the bench changes every input only on the falling edge. The assertions also assume that `en_set_i` never tries to set the bit of a source in the cycle its service ends. The bench sets enable bits only while the sequencer is quiet, so this never happens.

// File: rtl/dts_pkg.sv
package dts_pkg;
    localparam int AW = 16;
    localparam int DW = 8;

    typedef enum logic [2:0] {
        S_IDLE, S_VEC, S_VCAP, S_CTL, S_CLR, S_RD, S_WR, S_WB
    } seq_state_e;

    typedef struct packed {
        logic          rpt;    // cyclic mode
        logic          chn;    // chain to next record
        logic          rpti;   // interrupt on reload
        logic          sinc;   // source increments
        logic          dinc;   // destination increments
        logic          side;   // 1: destination rewinds, 0: source rewinds
        logic [7:0]    cnt;
        logic [7:0]    rld;
        logic [AW-1:0] sa;
        logic [AW-1:0] da;
    } rec_t;
endpackage

// File: rtl/dts_pick.sv
module dts_pick #(
    parameter int N  = 8,
    parameter int SW = 3
) (
    input  logic [N-1:0]  vec_i,
    output logic          vld_o,
    output logic [SW-1:0] sel_o
);
    logic [N:0]   seen;
    logic [N-1:0] hit;

    assign seen[0] = 1'b0;
    for (genvar g = 0; g < N; g++) begin : g_pri
        assign hit[g]    = vec_i[g] & ~seen[g];
        assign seen[g+1] = seen[g] | vec_i[g];
    end

    assign vld_o = seen[N];

    always_comb begin
        sel_o = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) sel_o = SW'(i);
        end
    end
endmodule

// File: rtl/dts_rec_upd.sv
module dts_rec_upd
    import dts_pkg::*;
(
    input  rec_t rec_i,
    output rec_t rec_o,
    output logic term_o
);
    logic          hit;
    logic [AW-1:0] span;

    always_comb begin
        rec_o = rec_i;
        hit   = (rec_i.cnt == 8'd1);
        span  = (rec_i.rld == 8'd0) ? AW'(256) : AW'(rec_i.rld);
        rec_o.cnt = rec_i.cnt - 8'd1;
        if (rec_i.sinc) rec_o.sa = rec_i.sa + AW'(1);
        if (rec_i.dinc) rec_o.da = rec_i.da + AW'(1);
        if (rec_i.rpt && hit) begin
            rec_o.cnt = rec_i.rld;
            if (rec_i.side && rec_i.dinc)  rec_o.da = rec_o.da - span;
            if (!rec_i.side && rec_i.sinc) rec_o.sa = rec_o.sa - span;
        end
        term_o = hit && (!rec_i.rpt || rec_i.rpti);
    end
endmodule

// File: rtl/dts_seq.sv
module dts_seq
    import dts_pkg::*;
#(
    parameter int             NUM_SRC   = 8,
    parameter int             NUM_REC   = 24,
    parameter logic [15:0]    VEC_BASE  = 16'h0000,
    parameter logic [15:0]    STAT_BASE = 16'h0040,
    parameter logic [15:0]    REC_BASE  = 16'h0100,
    parameter logic [NUM_SRC-1:0] CLR_MASK = 8'hC0,
    localparam int            SW = $clog2(NUM_SRC),
    localparam int            IW = $clog2(NUM_REC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    output logic [NUM_SRC-1:0] ack_o,
    input  logic [NUM_SRC-1:0] en_set_i,
    output logic [NUM_SRC-1:0] en_o,
    input  logic               nmi_i,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [15:0]        mem_addr_o,
    output logic [7:0]         mem_wdata_o,
    input  logic [7:0]         mem_rdata_i,
    output logic               irq_o,
    output logic [SW-1:0]      irq_src_o,
    output logic               busy_o
);
    localparam logic [7:0]    REC_LIM  = 8'(NUM_REC);
    localparam logic [IW-1:0] LAST_REC = IW'(NUM_REC - 1);
    localparam logic [2:0]    CTL_LAST = 3'd7;
    localparam logic [2:0]    WB_LAST  = 3'd5;

    typedef struct packed {
        seq_state_e         st;
        logic [2:0]         cnt;
        logic [SW-1:0]      src;
        logic [IW-1:0]      idx;
        logic               first;
        rec_t               rec;
        logic               term;
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] ack;
        logic               irq;
        logic [SW-1:0]      irq_src;
    } seq_t;

    seq_t q, d;

    logic          pk_vld;
    logic [SW-1:0] pk_sel;
    rec_t          upd_rec;
    logic          upd_term;
    logic [15:0]   rec_addr;

    dts_pick #(.N(NUM_SRC), .SW(SW)) u_pick (
        .vec_i (q.pend & q.en),
        .vld_o (pk_vld),
        .sel_o (pk_sel)
    );

    dts_rec_upd u_upd (
        .rec_i  (q.rec),
        .rec_o  (upd_rec),
        .term_o (upd_term)
    );

    assign rec_addr = REC_BASE + {{(16-IW-3){1'b0}}, q.idx, 3'b000};

    always_comb begin
        d           = q;
        d.ack       = '0;
        d.irq       = 1'b0;
        d.en        = q.en | en_set_i;
        d.pend      = q.pend | (req_i & q.en);
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;

        case (q.st)
            S_IDLE: begin
                if (pk_vld) begin
                    d.ack[pk_sel]  = 1'b1;
                    d.pend[pk_sel] = 1'b0;
                    if (!nmi_i) begin
                        d.st    = S_VEC;
                        d.src   = pk_sel;
                        d.first = 1'b1;
                    end
                end
            end
            S_VEC: begin
                mem_req_o  = 1'b1;
                mem_addr_o = VEC_BASE + 16'(q.src);
                d.st       = S_VCAP;
            end
            S_VCAP: begin
                if (mem_rdata_i < REC_LIM) begin
                    d.idx = mem_rdata_i[IW-1:0];
                    d.cnt = '0;
                    d.st  = S_CTL;
                end else begin
                    d.st = S_IDLE;
                end
            end
            S_CTL: begin
                if (q.cnt != CTL_LAST) begin
                    mem_req_o  = 1'b1;
                    mem_addr_o = rec_addr + 16'(q.cnt);
                end
                case (q.cnt)
                    3'd1: begin
                        d.rec.rpt  = mem_rdata_i[0];
                        d.rec.chn  = mem_rdata_i[1];
                        d.rec.rpti = mem_rdata_i[2];
                        d.rec.sinc = mem_rdata_i[3];
                        d.rec.dinc = mem_rdata_i[4];
                        d.rec.side = mem_rdata_i[5];
                    end
                    3'd2: d.rec.cnt      = mem_rdata_i;
                    3'd3: d.rec.rld      = mem_rdata_i;
                    3'd4: d.rec.sa[7:0]  = mem_rdata_i;
                    3'd5: d.rec.sa[15:8] = mem_rdata_i;
                    3'd6: d.rec.da[7:0]  = mem_rdata_i;
                    3'd7: d.rec.da[15:8] = mem_rdata_i;
                    default: ;
                endcase
                if (q.cnt == CTL_LAST) begin
                    d.st = (q.first && CLR_MASK[q.src]) ? S_CLR : S_RD;
                end else begin
                    d.cnt = q.cnt + 3'd1;
                end
            end
            S_CLR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = STAT_BASE + 16'(q.src);
                mem_wdata_o = 8'h00;
                d.st        = S_RD;
            end
            S_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.rec.sa;
                d.st       = S_WR;
            end
            S_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = q.rec.da;
                mem_wdata_o = mem_rdata_i;
                d.rec       = upd_rec;
                d.term      = upd_term;
                d.cnt       = '0;
                d.st        = S_WB;
            end
            S_WB: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = rec_addr + 16'(q.cnt) + 16'd1;
                case (q.cnt)
                    3'd0:    mem_wdata_o = q.rec.cnt;
                    3'd1:    mem_wdata_o = q.rec.rld;
                    3'd2:    mem_wdata_o = q.rec.sa[7:0];
                    3'd3:    mem_wdata_o = q.rec.sa[15:8];
                    3'd4:    mem_wdata_o = q.rec.da[7:0];
                    default: mem_wdata_o = q.rec.da[15:8];
                endcase
                if (q.cnt == WB_LAST) begin
                    if (q.term) begin
                        d.en[q.src] = 1'b0;
                        d.irq       = 1'b1;
                        d.irq_src   = q.src;
                    end
                    if (q.rec.chn && q.idx != LAST_REC) begin
                        d.idx   = q.idx + IW'(1);
                        d.cnt   = '0;
                        d.first = 1'b0;
                        d.st    = S_CTL;
                    end else begin
                        d.st = S_IDLE;
                    end
                end else begin
                    d.cnt = q.cnt + 3'd1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ack_o     = q.ack;
    assign en_o      = q.en;
    assign irq_o     = q.irq;
    assign irq_src_o = q.irq_src;
    assign busy_o    = (q.st != S_IDLE);
endmodule

// File: rtl/dts_chk.sv
module dts_chk #(
    parameter int NUM_SRC = 8,
    localparam int SW = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy_o,
    input logic               mem_req_o,
    input logic [NUM_SRC-1:0] ack_o,
    input logic [NUM_SRC-1:0] en_o,
    input logic               nmi_i,
    input logic               irq_o,
    input logic [SW-1:0]      irq_src_o
);
    assert_req_in_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o);

    assert_ack_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));

    assert_ack_after_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |-> !$past(busy_o));

    assert_nmi_cancel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |-> (busy_o == !$past(nmi_i)));

    assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_irq_disables_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !en_o[irq_src_o]);
endmodule

bind dts_seq dts_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .mem_req_o (mem_req_o),
    .ack_o     (ack_o),
    .en_o      (en_o),
    .nmi_i     (nmi_i),
    .irq_o     (irq_o),
    .irq_src_o (irq_src_o)
);

// File: tb/sim_dts_seq.sv
module sim_dts_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req_i = '0;
    logic [7:0]  ack_o;
    logic [7:0]  en_set_i = '0;
    logic [7:0]  en_o;
    logic        nmi_i = 1'b0;
    logic        mem_req_o, mem_we_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i = '0;
    logic        irq_o;
    logic [2:0]  irq_src_o;
    logic        busy_o;

    always #10 clk = ~clk;

    dts_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_o(ack_o),
        .en_set_i(en_set_i), .en_o(en_o), .nmi_i(nmi_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .irq_o(irq_o), .irq_src_o(irq_src_o), .busy_o(busy_o)
    );

    logic [7:0]  mem [0:2047];
    logic [15:0] log_a [0:511];
    logic        log_w [0:511];
    int nlog = 0, acc = 0, viol = 0, irq_cnt = 0, ack_cnt = 0, cyc = 0;
    int last_irq = -1;
    int n_tests = 0, n_fail = 0;

    always @(posedge clk) begin
        if (mem_req_o) begin
            if (mem_we_o) mem[mem_addr_o[10:0]] <= mem_wdata_o;
            else          mem_rdata_i <= mem[mem_addr_o[10:0]];
            acc <= acc + 1;
            if (nlog < 512) begin
                log_a[nlog] <= mem_addr_o;
                log_w[nlog] <= mem_we_o;
                nlog <= nlog + 1;
            end
            if (!busy_o) viol <= viol + 1;
        end
        if (irq_o) begin
            irq_cnt  <= irq_cnt + 1;
            last_irq <= int'(irq_src_o);
        end
        ack_cnt <= ack_cnt + $countones(ack_o);
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_tests = n_tests + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    task automatic quiet();
        int k = 0;
        while (k < 4) begin
            @(negedge clk);
            if (busy_o) k = 0; else k = k + 1;
        end
    endtask

    task automatic enable(input logic [7:0] m);
        @(negedge clk); en_set_i = m;
        @(negedge clk); en_set_i = '0;
    endtask

    task automatic request(input logic [7:0] m);
        @(negedge clk); req_i = m;
        @(negedge clk); req_i = '0;
    endtask

    task automatic set_rec(input int idx, input int fl, input int cn, input int rl,
                           input int sa, input int da);
        int b = 256 + idx * 8;
        mem[b]   = 8'(fl); mem[b+1] = 8'(cn); mem[b+2] = 8'(rl);
        mem[b+3] = 8'(sa);  mem[b+4] = 8'(sa >> 8);
        mem[b+5] = 8'(da);  mem[b+6] = 8'(da >> 8);
        mem[b+7] = 8'h00;
    endtask

    function automatic int rd16(input int a);
        return int'({mem[a+1], mem[a]});
    endfunction

    task automatic t_reset();
        chk(busy_o == 1'b0 && mem_req_o == 1'b0, "R1 idle", int'(busy_o), 0);
        chk(en_o == 8'h00 && ack_o == 8'h00 && irq_o == 1'b0, "R1 outputs", int'(en_o), 0);
    endtask

    task automatic t_disabled();
        int a0 = acc, k0 = ack_cnt;
        request(8'h08);
        repeat (20) @(negedge clk);
        enable(8'h08);
        repeat (20) @(negedge clk);
        chk(acc == a0, "R2 no access", acc - a0, 0);
        chk(ack_cnt == k0, "R2 no ack", ack_cnt - k0, 0);
    endtask

    task automatic t_order();
        int s;
        int exp_a [16];
        bit exp_w [16];
        bit ok = 1'b1;
        mem[0] = 8'd2;
        set_rec(2, 8'h18, 5, 0, 16'h0400, 16'h0500);
        mem[16'h400] = 8'hA5;
        enable(8'h01);
        s = nlog;
        request(8'h01);
        quiet();
        exp_a[0] = 0; exp_w[0] = 0;
        for (int k = 0; k < 7; k++) begin exp_a[1+k] = 16'h110 + k; exp_w[1+k] = 0; end
        exp_a[8] = 16'h400; exp_w[8] = 0;
        exp_a[9] = 16'h500; exp_w[9] = 1;
        for (int k = 0; k < 6; k++) begin exp_a[10+k] = 16'h111 + k; exp_w[10+k] = 1; end
        chk(nlog - s == 16, "R4 access count", nlog - s, 16);
        for (int k = 0; k < 16; k++) begin
            if (int'(log_a[s+k]) != exp_a[k] || log_w[s+k] != exp_w[k]) ok = 1'b0;
        end
        chk(ok, "R4 access order", int'(log_a[s+9]), exp_a[9]);
        chk(mem[16'h500] == 8'hA5, "R5 data copied", int'(mem[16'h500]), 8'hA5);
        chk(mem[16'h111] == 8'd4, "R5 count decremented", int'(mem[16'h111]), 4);
        chk(rd16(16'h113) == 16'h0401 && rd16(16'h115) == 16'h0501, "R5 addresses advanced",
            rd16(16'h115), 16'h0501);
        chk(en_o[0] == 1'b1, "R5 enable kept", int'(en_o[0]), 1);
    endtask

    task automatic t_normal_term();
        int i0 = irq_cnt;
        mem[1] = 8'd3;
        set_rec(3, 8'h08, 1, 0, 16'h0410, 16'h0510);
        mem[16'h410] = 8'h3C;
        enable(8'h02);
        request(8'h02);
        quiet();
        chk(mem[16'h119] == 8'd0, "R6 count zero", int'(mem[16'h119]), 0);
        chk(mem[16'h510] == 8'h3C, "R6 data", int'(mem[16'h510]), 8'h3C);
        chk(en_o[1] == 1'b0, "R6 enable cleared", int'(en_o[1]), 0);
        chk(irq_cnt == i0 + 1 && last_irq == 1, "R6 irq src", last_irq, 1);
    endtask

    task automatic t_zero_count();
        int i0 = irq_cnt;
        mem[1] = 8'd4;
        set_rec(4, 8'h00, 0, 0, 16'h0410, 16'h0511);
        enable(8'h02);
        request(8'h02);
        quiet();
        chk(mem[16'h121] == 8'hFF, "R12 wrap to 255", int'(mem[16'h121]), 255);
        chk(irq_cnt == i0 && en_o[1] == 1'b1, "R12 no irq", irq_cnt - i0, 0);
    endtask

    task automatic t_repeat();
        int i0 = irq_cnt;
        mem[2] = 8'd5;
        set_rec(5, 8'h31, 1, 3, 16'h0420, 16'h0602);
        mem[16'h420] = 8'h77;
        enable(8'h04);
        request(8'h04);
        quiet();
        chk(mem[16'h602] == 8'h77, "R7 data", int'(mem[16'h602]), 8'h77);
        chk(mem[16'h129] == 8'd3, "R7 count reloaded", int'(mem[16'h129]), 3);
        chk(rd16(16'h12D) == 16'h0600, "R7 dest rewound", rd16(16'h12D), 16'h0600);
        chk(rd16(16'h12B) == 16'h0420, "R7 src fixed", rd16(16'h12B), 16'h0420);
        chk(irq_cnt == i0 && en_o[2] == 1'b1, "R7 no irq without flag", irq_cnt - i0, 0);
        set_rec(5, 8'h35, 1, 2, 16'h0420, 16'h0612);
        request(8'h04);
        quiet();
        chk(rd16(16'h12D) == 16'h0611 && mem[16'h129] == 8'd2, "R7 rewind by reload",
            rd16(16'h12D), 16'h0611);
        chk(irq_cnt == i0 + 1 && last_irq == 2 && en_o[2] == 1'b0, "R7 irq with flag",
            irq_cnt - i0, 1);
    endtask

    task automatic t_chain();
        int s, nv = 0;
        mem[3] = 8'd7;
        set_rec(7, 8'h02, 9, 0, 16'h0430, 16'h0530);
        set_rec(8, 8'h00, 9, 0, 16'h0431, 16'h0531);
        set_rec(9, 8'h00, 9, 0, 16'h0432, 16'h0532);
        mem[16'h430] = 8'h11; mem[16'h431] = 8'h22; mem[16'h432] = 8'h33;
        mem[16'h530] = 8'h00; mem[16'h531] = 8'h00; mem[16'h532] = 8'h00;
        s = nlog;
        request(8'h08);
        quiet();
        for (int k = s; k < nlog; k++) if (log_a[k] < 16'h40 && !log_w[k]) nv++;
        chk(mem[16'h530] == 8'h11 && mem[16'h531] == 8'h22, "R8 both records moved",
            int'(mem[16'h531]), 8'h22);
        chk(mem[16'h532] == 8'h00 && mem[16'h149] == 8'd9, "R8 chain stops",
            int'(mem[16'h532]), 0);
        chk(nv == 1 && nlog - s == 31, "R8 single vector read", nlog - s, 31);
    endtask

    task automatic t_chain_end();
        int s, a0;
        bit wrap = 1'b0;
        mem[4] = 8'd23;
        set_rec(23, 8'h02, 9, 0, 16'h0440, 16'h0540);
        mem[16'h440] = 8'h5A;
        enable(8'h10);
        s = nlog;
        request(8'h10);
        quiet();
        for (int k = s; k < nlog; k++) if (log_a[k] >= 16'h100 && log_a[k] < 16'h108) wrap = 1'b1;
        chk(mem[16'h540] == 8'h5A && mem[16'h1B9] == 8'd8, "R9 last record done",
            int'(mem[16'h1B9]), 8);
        chk(!wrap && nlog - s == 16, "R9 no wrap", nlog - s, 16);
        mem[4] = 8'd30;
        a0 = acc;
        request(8'h10);
        quiet();
        chk(acc - a0 == 1, "R9 bad vector", acc - a0, 1);
    endtask

    task automatic t_nmi();
        int a0, k0;
        mem[5] = 8'd12;
        set_rec(12, 8'h00, 9, 0, 16'h0450, 16'h0560);
        enable(8'h20);
        a0 = acc; k0 = ack_cnt;
        @(negedge clk); nmi_i = 1'b1;
        request(8'h20);
        repeat (10) @(negedge clk);
        chk(acc == a0 && busy_o == 1'b0, "R3 no access under nmi", acc - a0, 0);
        chk(ack_cnt == k0 + 1, "R3 ack", ack_cnt - k0, 1);
        nmi_i = 1'b0;
        repeat (20) @(negedge clk);
        chk(acc == a0, "R3 request dropped", acc - a0, 0);
    endtask

    task automatic t_clr();
        int s, nw = 0;
        mem[6] = 8'd10;
        set_rec(10, 8'h02, 9, 0, 16'h0450, 16'h0550);
        set_rec(11, 8'h00, 9, 0, 16'h0451, 16'h0551);
        mem[16'h450] = 8'h01; mem[16'h451] = 8'h02;
        mem[16'h046] = 8'hFF;
        enable(8'h40);
        s = nlog;
        request(8'h40);
        quiet();
        for (int k = s; k < nlog; k++) if (log_a[k] == 16'h46 && log_w[k]) nw++;
        chk(mem[16'h046] == 8'h00, "R10 status cleared", int'(mem[16'h046]), 0);
        chk(log_a[s+8] == 16'h0046 && log_w[s+8] && log_a[s+9] == 16'h0450,
            "R10 position", int'(log_a[s+8]), 16'h46);
        chk(nw == 1 && nlog - s == 32, "R10 once per activation", nw, 1);
        chk(mem[16'h550] == 8'h01 && mem[16'h551] == 8'h02, "R10 data", int'(mem[16'h551]), 2);
    endtask

    task automatic t_pending();
        int s, nv = 0;
        int vs [3];
        mem[5] = 8'd12; mem[1] = 8'd13; mem[2] = 8'd14;
        set_rec(12, 8'h00, 9, 0, 16'h0460, 16'h0570);
        set_rec(13, 8'h00, 9, 0, 16'h0461, 16'h0571);
        set_rec(14, 8'h00, 9, 0, 16'h0462, 16'h0572);
        enable(8'h26);
        s = nlog;
        request(8'h20);
        repeat (4) @(negedge clk);
        chk(busy_o == 1'b1, "R11 busy while serving", int'(busy_o), 1);
        request(8'h06);
        quiet();
        for (int k = s; k < nlog; k++) begin
            if (log_a[k] < 16'h40 && !log_w[k]) begin
                if (nv < 3) vs[nv] = int'(log_a[k]);
                nv++;
            end
        end
        chk(nv == 3, "R11 all served", nv, 3);
        chk(vs[0] == 5 && vs[1] == 1 && vs[2] == 2, "R11 ascending order", vs[1] * 16 + vs[2], 16'h12);
    endtask

    initial begin
        for (int k = 0; k < 2048; k++) mem[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_order();
        t_normal_term();
        t_zero_count();
        t_repeat();
        t_chain();
        t_chain_end();
        t_nmi();
        t_clr();
        t_pending();
        chk(viol == 0 && busy_o == 1'b0, "R13 access only while busy", viol, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule